// File: doc/BRIEF.md
# Processor Clock Source Selector

This block produces the processor clock enable for a subsystem that can run either from a fast PLL source or from a slower crystal reference. Both sources arrive as single-cycle tick inputs on the block clock: the reference ticks at 16 MHz and the PLL ticks at 240 MHz, which is fifteen times the reference. The block counts ticks of the selected source and emits one enable pulse per divided period. The PLL path divides by 6 (40 MHz) or by 7 (about 34.3 MHz). The low-power path divides the reference by 2, 16, 64 or 512, giving 8 MHz, 1 MHz, 250 kHz or 31.25 kHz.

Software selects the source and divisor through a small register port. The port holds a mode register, a fixed identification word and a read-only status word that shows which source is actually driving the enable. Changes are applied only when the running period ends, so the enable never has a shortened period. A move onto the PLL also waits for the PLL-ready input. After reset the block runs at the slowest low-power setting. A boot-ready output rises once ten enable pulses have been produced, which marks the point where the first instruction fetch may begin.

Top module: `proc_clk_select`

## Requirements
- R1: While reset is asserted and after it is released, the mode register reads 0x31 (low-power on, slow off, select 3), the status word reads 1, and clk_en and boot_ready are 0. The internal logic leaves reset two clock edges after rst_n rises.
- R2: With mode bit 0 (low-power) set, one clk_en pulse is produced for every 2, 16, 64 or 512 reference ticks, for select field values 0, 1, 2 and 3 in mode bits 5:4.
- R3: With low-power clear and the PLL source in use, one clk_en pulse is produced for every 6 PLL ticks when mode bit 1 (slow) is 0, and for every 7 PLL ticks when it is 1.
- R4: The source moves to the PLL only at the end of a period and only if pll_ready is high on that cycle. Otherwise the current source and divisor are kept.
- R5: A new source or divisor takes effect only on the cycle that ends the current period. clk_en is never high on two consecutive cycles, and every period is a whole count of the divisor then in force.
- R6: Reading offset 0xC returns bit 0 = 1 while the reference drives the enable and 0 while the PLL drives it. The bit changes on the same edge as the source.
- R7: Reading offset 0x4 returns 0x00010221, and reading any other unmapped offset returns 0. Writes to any offset other than 0x0 leave the mode register unchanged.
- R8: boot_ready rises on the cycle after the tenth clk_en pulse since reset and then stays high until the next reset.
- R9: A write to offset 0x0 stores bit 0 (low-power), bit 1 (slow) and bits 5:4 (select). A read returns those fields in place with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle tick at the 16 MHz reference rate |
| pll_tick | input | 1 | One-cycle tick at the 240 MHz PLL rate |
| pll_ready | input | 1 | PLL locked and usable |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| clk_en | output | 1 | Processor clock enable, one cycle per divided period |
| boot_ready | output | 1 | High once ten enable pulses have been issued |

## Verification
The assertions assume that the tick inputs are single-cycle strobes synchronous to clk, and that pll_ready and the register port are also synchronous to clk. They allow a tick on every cycle; the pulse-width property relies on every divisor being at least 2. The stimulus drives every input on the falling edge from a free-running tick generator. The PLL tick period ranges over one and two cycles and the reference period is four cycles. pll_ready is toggled only while the bench is waiting for a boundary, so that both the held case and the switching case occur.

// File: rtl/proc_clk_pkg.sv
package proc_clk_pkg;

  localparam int unsigned DIV_W = 10;

  // Low-power divisor selected by the two-bit select field.
  function automatic logic [DIV_W-1:0] lp_divisor(input logic [1:0] sel);
    logic [DIV_W-1:0] d;
    case (sel)
      2'd0:    d = DIV_W'(2);
      2'd1:    d = DIV_W'(16);
      2'd2:    d = DIV_W'(64);
      default: d = DIV_W'(512);
    endcase
    return d;
  endfunction

  typedef struct packed {
    logic             lp;
    logic             slow;
    logic [1:0]       sel;
  } mode_t;

endpackage

// File: rtl/clk_rst_sync.sv
module clk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/clk_mode_regs.sv
module clk_mode_regs
  import proc_clk_pkg::*;
#(
  parameter int unsigned    ADDR_W  = 4,
  parameter int unsigned    DATA_W  = 32,
  parameter logic [31:0]    CHIP_ID = 32'h0001_0221
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              src_on_ref,
  output mode_t             mode,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] OFS_MODE   = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFS_ID     = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(4'hC);
  localparam mode_t MODE_RST = '{lp: 1'b1, slow: 1'b0, sel: 2'b11};

  mode_t mode_q, mode_d;
  logic  unused_wdata_bits;

  assign unused_wdata_bits = ^{wdata[DATA_W-1:6], wdata[3:2]};

  always_comb begin
    mode_d = mode_q;
    if (wr_en && addr == OFS_MODE) begin
      mode_d.lp   = wdata[0];
      mode_d.slow = wdata[1];
      mode_d.sel  = wdata[5:4];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) mode_q <= MODE_RST;
    else         mode_q <= mode_d;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_MODE:   rdata[5:0] = {mode_q.sel, 2'b00, mode_q.slow, mode_q.lp};
      OFS_ID:     rdata      = DATA_W'(CHIP_ID);
      OFS_STATUS: rdata[0]   = src_on_ref;
      default:    rdata      = '0;
    endcase
  end

  assign mode = mode_q;

  assert_wr_elsewhere_ignored_R7: assert property (@(posedge clk) disable iff (!srst_n)
    !(wr_en && addr == OFS_MODE) |=> $stable(mode_q))
    else $error("mode register changed without a write to offset 0");
endmodule

// File: rtl/clk_period_gen.sv
module clk_period_gen
  import proc_clk_pkg::*;
#(
  parameter int unsigned PLL_DIV_FAST = 6,
  parameter int unsigned PLL_DIV_SLOW = 7
) (
  input  logic  clk,
  input  logic  srst_n,
  input  logic  ref_tick,
  input  logic  pll_tick,
  input  logic  pll_ready,
  input  mode_t mode,
  output logic  clk_en,
  output logic  on_ref
);
  localparam logic [DIV_W-1:0] DIV_FAST = DIV_W'(PLL_DIV_FAST);
  localparam logic [DIV_W-1:0] DIV_SLOW = DIV_W'(PLL_DIV_SLOW);
  localparam logic [DIV_W-1:0] DIV_RST  = lp_divisor(2'b11);

  logic             on_ref_q, on_ref_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             en_q, en_d;
  logic             tick, at_end;
  logic             cfg_ref;
  logic [DIV_W-1:0] cfg_div;

  assign tick   = on_ref_q ? ref_tick : pll_tick;
  assign at_end = tick && (cnt_q == div_q - 1'b1);

  // Configuration to load at the next period boundary.
  always_comb begin
    cfg_ref = on_ref_q;
    cfg_div = div_q;
    if (mode.lp) begin
      cfg_ref = 1'b1;
      cfg_div = lp_divisor(mode.sel);
    end else if (pll_ready) begin
      cfg_ref = 1'b0;
      cfg_div = mode.slow ? DIV_SLOW : DIV_FAST;
    end
  end

  always_comb begin
    en_d     = at_end;
    cnt_d    = cnt_q;
    on_ref_d = on_ref_q;
    div_d    = div_q;
    if (at_end) begin
      cnt_d    = '0;
      on_ref_d = cfg_ref;
      div_d    = cfg_div;
    end else if (tick) begin
      cnt_d    = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      on_ref_q <= 1'b1;
      div_q    <= DIV_RST;
      cnt_q    <= '0;
      en_q     <= 1'b0;
    end else begin
      on_ref_q <= on_ref_d;
      div_q    <= div_d;
      cnt_q    <= cnt_d;
      en_q     <= en_d;
    end
  end

  assign clk_en = en_q;
  assign on_ref = on_ref_q;

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!srst_n)
    en_q |=> !en_q)
    else $error("clock enable high on two consecutive cycles");

  assert_div_at_boundary_R5: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(div_q) |-> en_q)
    else $error("divisor changed away from a period boundary");

  assert_src_at_boundary_R6: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(on_ref_q) |-> en_q)
    else $error("source changed away from a period boundary");

  assert_pll_needs_ready_R4: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(on_ref_q) |-> $past(pll_ready))
    else $error("moved to PLL source without PLL ready");

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_q < div_q)
    else $error("period counter beyond divisor");
endmodule

// File: rtl/clk_boot_gate.sv
module clk_boot_gate #(
  parameter int unsigned BOOT_PULSES = 10
) (
  input  logic clk,
  input  logic srst_n,
  input  logic clk_en,
  output logic boot_ready
);
  localparam int unsigned CW = $clog2(BOOT_PULSES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(BOOT_PULSES);

  logic [CW-1:0] cnt_q, cnt_d;

  assign boot_ready = (cnt_q == LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (clk_en && !boot_ready) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!srst_n)
    boot_ready |=> boot_ready)
    else $error("boot ready dropped");
endmodule

// File: rtl/proc_clk_select.sv
module proc_clk_select
  import proc_clk_pkg::*;
#(
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned PLL_DIV_FAST = 6,
  parameter int unsigned PLL_DIV_SLOW = 7,
  parameter int unsigned BOOT_PULSES  = 10,
  parameter logic [31:0] CHIP_ID      = 32'h0001_0221
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              pll_tick,
  input  logic              pll_ready,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              clk_en,
  output logic              boot_ready
);
  logic  srst_n;
  logic  on_ref;
  mode_t mode;

  clk_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  clk_mode_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHIP_ID(CHIP_ID)) u_regs (
    .clk(clk), .srst_n(srst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .src_on_ref(on_ref), .mode(mode), .rdata(reg_rdata)
  );

  clk_period_gen #(.PLL_DIV_FAST(PLL_DIV_FAST), .PLL_DIV_SLOW(PLL_DIV_SLOW)) u_gen (
    .clk(clk), .srst_n(srst_n), .ref_tick(ref_tick), .pll_tick(pll_tick),
    .pll_ready(pll_ready), .mode(mode), .clk_en(clk_en), .on_ref(on_ref)
  );

  clk_boot_gate #(.BOOT_PULSES(BOOT_PULSES)) u_boot (
    .clk(clk), .srst_n(srst_n), .clk_en(clk_en), .boot_ready(boot_ready)
  );
endmodule

// File: tb/proc_clk_select_test.sv
`timescale 1ns/1ps
module proc_clk_select_test;
  logic        clk = 1'b0;
  logic        rst_n, ref_tick, pll_tick, pll_ready, reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        clk_en, boot_ready;

  int checks = 0, fails = 0, cycles = 0;
  int ref_per = 4, pll_per = 1, rc = 0, pc = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  proc_clk_select uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pll_tick(pll_tick),
    .pll_ready(pll_ready), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en(clk_en),
    .boot_ready(boot_ready)
  );

  // Tick generators driven on the falling edge.
  always @(negedge clk) begin
    rc = (rc + 1 >= ref_per) ? 0 : rc + 1;
    pc = (pc + 1 >= pll_per) ? 0 : pc + 1;
    ref_tick = (rc == 0);
    pll_tick = (pc == 0);
  end

  // Behavioural reference model.
  bit m_s0, m_s1, m_lp, m_slow, m_on_ref, m_en;
  bit [1:0] m_sel;
  int m_div, m_cnt, m_boot;

  function automatic int lp_div(input bit [1:0] s);
    case (s)
      2'd0: return 2;
      2'd1: return 16;
      2'd2: return 64;
      default: return 512;
    endcase
  endfunction

  task automatic model_reset();
    m_s0 = 0; m_s1 = 0; m_lp = 1; m_slow = 0; m_sel = 2'b11;
    m_on_ref = 1; m_en = 0; m_div = 512; m_cnt = 0; m_boot = 0;
  endtask

  always @(posedge clk) begin
    bit tk, last;
    cycles++;
    if (!rst_n) model_reset();
    else begin
      if (m_s1) begin
        tk = m_on_ref ? ref_tick : pll_tick;
        if (m_en && m_boot < 10) m_boot++;
        last = tk && (m_cnt == m_div - 1);
        m_en = last;
        if (last) begin
          m_cnt = 0;
          if (m_lp) begin m_on_ref = 1; m_div = lp_div(m_sel); end
          else if (pll_ready) begin m_on_ref = 0; m_div = m_slow ? 7 : 6; end
        end else if (tk) m_cnt++;
        if (reg_wr && reg_addr == 4'h0) begin
          m_lp = reg_wdata[0]; m_slow = reg_wdata[1]; m_sel = reg_wdata[5:4];
        end
      end
      m_s1 = m_s0; m_s0 = 1;
    end
  end

  function automatic logic [31:0] model_rdata(input logic [3:0] a);
    case (a)
      4'h0: return {26'd0, m_sel, 2'b00, m_slow, m_lp};
      4'h4: return 32'h0001_0221;
      4'hC: return {31'd0, m_on_ref};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(posedge clk) begin
    #3;
    check(cur_req, "clk_en", {31'd0, clk_en}, {31'd0, m_en});
    check("R8", "boot_ready", {31'd0, boot_ready}, {31'd0, (m_boot >= 10)});
    check(cur_req, "rdata", reg_rdata, model_rdata(reg_addr));
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_addr = 4'hC; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(posedge clk); #3 d = reg_rdata;
    @(negedge clk); reg_addr = 4'hC;
  endtask

  // Watchdog.
  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 0; pll_ready = 0; reg_wr = 0; reg_addr = 4'hC; reg_wdata = '0;
    ref_tick = 0; pll_tick = 0;
    model_reset();
    wait_cyc(5);
    rd(4'h0, d); check("R1", "mode in reset", d, 32'h31);
    @(negedge clk); rst_n = 1;
    rd(4'hC, d); check("R1", "status after reset", d, 32'h1);
    check("R1", "boot_ready after reset", {31'd0, boot_ready}, 32'd0);

    cur_req = "R8";
    wait (boot_ready === 1'b1);
    wait_cyc(3);
    check("R8", "boot_ready held", {31'd0, boot_ready}, 32'd1);

    cur_req = "R2";
    wr(4'h0, 32'h01); rd(4'h0, d); check("R9", "mode readback lp sel0", d, 32'h01);
    wait_cyc(2200);
    wr(4'h0, 32'h11); wait_cyc(400);
    wr(4'h0, 32'h21); rd(4'h0, d); check("R9", "mode readback sel2", d, 32'h21);
    wait_cyc(1200);

    cur_req = "R4";
    wr(4'h0, 32'h00); wait_cyc(1000);
    rd(4'hC, d); check("R4", "held on reference without ready", d, 32'h1);

    cur_req = "R3";
    pll_ready = 1; wait_cyc(400);
    rd(4'hC, d); check("R6", "status on PLL", d, 32'h0);
    wr(4'h0, 32'h02); wait_cyc(300);
    pll_per = 2; wait_cyc(300);
    pll_per = 1;

    cur_req = "R5";
    wr(4'h0, 32'h01); wait_cyc(5);
    wr(4'h0, 32'h21); wait_cyc(600);
    rd(4'hC, d); check("R6", "status back on reference", d, 32'h1);
    pll_ready = 0; wr(4'h0, 32'h00); wait_cyc(300);
    pll_ready = 1; wait_cyc(300);

    cur_req = "R7";
    wr(4'h4, 32'hFFFF_FFFF); wr(4'h8, 32'h31);
    rd(4'h0, d); check("R7", "mode after stray writes", d, 32'h00);
    rd(4'h4, d); check("R7", "id word", d, 32'h0001_0221);
    rd(4'h8, d); check("R7", "unmapped read", d, 32'h0);

    cur_req = "R1";
    @(negedge clk); rst_n = 0; wait_cyc(3);
    check("R1", "clk_en in reset", {31'd0, clk_en}, 32'd0);
    rd(4'h0, d); check("R1", "mode after second reset", d, 32'h31);
    @(negedge clk); rst_n = 1; wait_cyc(50);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule